// File: doc/BRIEF.md
# Trimmed One-Second Prescaler with Test and Flag Outputs

This block turns an oscillator clock (nominally 32,768 cycles per second) into a one-cycle seconds tick and applies a digital trim for crystal error. The trim does not touch every second. A 64-minute schedule picks a number of minutes. In each picked minute the first second is either cut short by 128 oscillator cycles or stretched by 256 oscillator cycles. The change is made at the stage that divides by 256. A 6-bit signed calibration value sets how many minutes are picked and which way the trim goes.

The same block drives two open-drain style pins, where a level of 1 means released. The first is a square-wave test output that runs at 512 Hz in test mode and is not affected by the trim. The second is a general-purpose output. It shows a software-set level, or it reports oscillator failure when failure reporting is enabled. A stop input freezes the whole divider. A divider reset input restarts the prescaler and the schedule from their origin. The analog oscillator and the failure detector sit outside this block.

Top module: `cal_divider`

## Requirements
- R1: With no trim, every second lasts exactly 2^PRE_W oscillator cycles (32,768 by default). `sec_tick` is high for one cycle at the end of each second.
- R2: A magnitude field of 0 (cal_reg[4:0]) applies no trim, whatever the sign bit says.
- R3: With the sign bit cal_reg[5] = 1 (speed up), a trimmed second is 128 cycles shorter than nominal.
- R4: With the sign bit cal_reg[5] = 0 (slow down), a trimmed second is 256 cycles longer than nominal.
- R5: With magnitude N, only minutes 0 to 2N-1 of the 64-minute cycle are trimmed. Only the first second of each such minute is trimmed, and every other second stays nominal.
- R6: The minute index wraps from 63 back to 0, so the schedule repeats every 64 minutes. Minutes 62 and 63 are never trimmed, even at N = 31.
- R7: While `stop` is 1, the prescaler holds its count and no tick is produced. When `stop` returns to 0, counting resumes from the held count.
- R8: A one-cycle `div_rst` pulse clears the prescaler, the second-in-minute index and the minute-in-cycle index. The next second is then second 0 of minute 0.
- R9: When `stop` = 0, cal_reg[7] = 1 and cal_reg[6] = 1, `ft_o` toggles every 2^(PRE_W-10) cycles (512 Hz), and the trim does not affect it. In every other case `ft_o` is held at 1.
- R10: When `ofie` = 0, `out_o` follows cal_reg[7], one cycle later.
- R11: When `ofie` = 1, `out_o` is 0 while `osc_fail` is 1 and is 1 otherwise. Clearing either `ofie` or `osc_fail` ends the low level.
- R12: During `rst`, `sec_tick` is 0 and both `ft_o` and `out_o` are 1 (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one edge per oscillator cycle |
| rst | input | 1 | Synchronous active-high power-on reset |
| div_rst | input | 1 | Synchronous divider and schedule restart |
| cal_reg | input | 8 | [7] output level, [6] test enable, [5] sign (1 = speed up), [4:0] magnitude |
| stop | input | 1 | 1 freezes the divider and the test output |
| ofie | input | 1 | 1 makes `out_o` report oscillator failure |
| osc_fail | input | 1 | Oscillator failure flag from the detector |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| ft_o | output | 1 | 512 Hz test output, 1 = released |
| out_o | output | 1 | General-purpose or failure output, 1 = released |

## Verification
The assertions check on every cycle the local stage behaviour: the 128-cycle skip and the 256-cycle blank, the frozen count under stop, single-cycle ticks, the rule that trim never appears outside second 0 or in minutes 62 and 63, and the pin levels for each pin mode. Only the bench scenarios can show the whole-second lengths across a full 64-minute cycle, including the repeat at minute 64. The same holds for how far a divider reset reaches, since it is seen as a trimmed second after the minute index had moved past the trimmed range. Stop resuming from the held count and the test output staying at a steady rate through a trimmed second are also shown only by the scenarios.

// File: rtl/cal_divider_pkg.sv
package cal_divider_pkg;

  localparam int CAL_MIN_PER_CYCLE = 64;
  localparam int CAL_MIN_W         = $clog2(CAL_MIN_PER_CYCLE);
  localparam int CAL_MAG_W         = 5;
  localparam int CAL_STAGE_W       = 8;   // divide-by-256 stage
  localparam int CAL_SKIP_POINT    = 127; // last count before a 128-cycle skip

  typedef struct packed {
    logic                 out_lvl;
    logic                 ft_en;
    logic                 sign_up;
    logic [CAL_MAG_W-1:0] mag;
  } cal_word_t;

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_divider_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic div_rst,
  input  logic run,
  input  logic adj_pos,
  input  logic adj_neg,
  output logic sec_wrap,
  output logic tick_o
);

  localparam int HI_W = PRE_W - CAL_STAGE_W;

  logic [CAL_STAGE_W-1:0] lo_q;
  logic [HI_W-1:0]        hi_q;
  logic                   blanked_q;

  logic hi_zero, hi_full, lo_full;
  logic skip_now, blank_now, carry;

  assign hi_zero   = (hi_q == '0);
  assign hi_full   = &hi_q;
  assign lo_full   = &lo_q;

  // positive trim: jump over 128 counts once, early in the second
  assign skip_now  = run && adj_pos && hi_zero &&
                     (lo_q == CAL_STAGE_W'(CAL_SKIP_POINT));
  // negative trim: swallow one carry into the upper stage
  assign blank_now = run && adj_neg && hi_zero && lo_full && !blanked_q;
  assign carry     = run && lo_full && !blank_now;
  assign sec_wrap  = carry && hi_full;

  always_ff @(posedge clk) begin
    if (rst || div_rst) begin
      lo_q      <= '0;
      hi_q      <= '0;
      blanked_q <= 1'b0;
      tick_o    <= 1'b0;
    end else begin
      tick_o <= sec_wrap;
      if (run) begin
        if (skip_now) begin
          lo_q <= '0;
          hi_q <= hi_q + HI_W'(1);
        end else begin
          lo_q <= lo_q + CAL_STAGE_W'(1);
          if (carry) hi_q <= hi_q + HI_W'(1);
        end
        if (blank_now)     blanked_q <= 1'b1;
        else if (sec_wrap) blanked_q <= 1'b0;
      end
    end
  end

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst || div_rst)
    !run |=> ($stable(lo_q) && $stable(hi_q) && !tick_o)); // R7

  AST_POS_SKIP: assert property (@(posedge clk) disable iff (rst || div_rst)
    (run && adj_pos && hi_zero && lo_q == CAL_STAGE_W'(CAL_SKIP_POINT))
      |=> (lo_q == '0 && hi_q == HI_W'(1))); // R3

  AST_NEG_BLANK: assert property (@(posedge clk) disable iff (rst || div_rst)
    (run && adj_neg && hi_zero && lo_full && !blanked_q)
      |=> (lo_q == '0 && hi_q == '0 && blanked_q)); // R4

  AST_SINGLE_TICK: assert property (@(posedge clk) disable iff (rst || div_rst)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/cal_schedule.sv
module cal_schedule
  import cal_divider_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 div_rst,
  input  logic                 sec_wrap,
  input  logic                 sign_up,
  input  logic [CAL_MAG_W-1:0] mag,
  output logic                 adj_pos,
  output logic                 adj_neg
);

  localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  logic [SW-1:0]        sec_idx_q;
  logic [CAL_MIN_W-1:0] min_idx_q;
  logic                 sec_last, eligible;

  assign sec_last = (sec_idx_q == SW'(SEC_PER_MIN - 1));
  assign eligible = (sec_idx_q == '0) && (mag != '0) &&
                    ({1'b0, min_idx_q} < {1'b0, mag, 1'b0});
  assign adj_pos  = eligible && sign_up;
  assign adj_neg  = eligible && !sign_up;

  always_ff @(posedge clk) begin
    if (rst || div_rst) begin
      sec_idx_q <= '0;
      min_idx_q <= '0;
    end else if (sec_wrap) begin
      if (sec_last) begin
        sec_idx_q <= '0;
        min_idx_q <= min_idx_q + CAL_MIN_W'(1);
      end else begin
        sec_idx_q <= sec_idx_q + SW'(1);
      end
    end
  end

  AST_TRIM_WINDOW: assert property (@(posedge clk) disable iff (rst || div_rst)
    (adj_pos || adj_neg) |-> (min_idx_q < CAL_MIN_W'(62) && sec_idx_q == '0)); // R5

  AST_ZERO_MAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mag == '0) |-> !(adj_pos || adj_neg)); // R2

  AST_MINUTE_STEP: assert property (@(posedge clk) disable iff (rst || div_rst)
    (sec_wrap && sec_last) |=> (min_idx_q == $past(min_idx_q) + CAL_MIN_W'(1))); // R6

endmodule

// File: rtl/cal_pins.sv
module cal_pins #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic div_rst,
  input  logic run,
  input  logic out_lvl,
  input  logic ft_en,
  input  logic ofie,
  input  logic osc_fail,
  output logic ft_o,
  output logic out_o
);

  localparam int HALF_W = PRE_W - 10; // half period of 512 Hz = 2^(PRE_W-10)

  logic test_mode;
  logic phase_q;

  assign test_mode = run && out_lvl && ft_en;

  generate
    if (HALF_W == 0) begin : g_fast
      always_ff @(posedge clk) begin
        if (rst || div_rst)  phase_q <= 1'b0;
        else if (run)        phase_q <= !phase_q;
      end
    end else begin : g_count
      logic [HALF_W-1:0] half_q;
      always_ff @(posedge clk) begin
        if (rst || div_rst) begin
          half_q  <= '0;
          phase_q <= 1'b0;
        end else if (run) begin
          half_q <= half_q + HALF_W'(1);
          if (&half_q) phase_q <= !phase_q;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_o  <= 1'b1;
      out_o <= 1'b1;
    end else begin
      ft_o  <= !test_mode || phase_q;
      out_o <= ofie ? !osc_fail : out_lvl;
    end
  end

  AST_FT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> ft_o); // R9

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !ofie |=> (out_o == $past(out_lvl))); // R10

  AST_FAIL_LOW: assert property (@(posedge clk) disable iff (rst)
    (ofie && osc_fail) |=> !out_o); // R11

  AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ofie && !osc_fail) |=> out_o); // R11

endmodule

// File: rtl/cal_divider.sv
module cal_divider
  import cal_divider_pkg::*;
#(
  parameter int PRE_W       = 15,
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       div_rst,
  input  logic [7:0] cal_reg,
  input  logic       stop,
  input  logic       ofie,
  input  logic       osc_fail,
  output logic       sec_tick,
  output logic       ft_o,
  output logic       out_o
);

  cal_word_t cw;
  logic      run, sec_wrap, adj_pos, adj_neg;

  assign cw  = cal_word_t'(cal_reg);
  assign run = !stop;

  cal_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .div_rst  (div_rst),
    .run      (run),
    .adj_pos  (adj_pos),
    .adj_neg  (adj_neg),
    .sec_wrap (sec_wrap),
    .tick_o   (sec_tick)
  );

  cal_schedule #(.SEC_PER_MIN(SEC_PER_MIN)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .div_rst  (div_rst),
    .sec_wrap (sec_wrap),
    .sign_up  (cw.sign_up),
    .mag      (cw.mag),
    .adj_pos  (adj_pos),
    .adj_neg  (adj_neg)
  );

  cal_pins #(.PRE_W(PRE_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .div_rst  (div_rst),
    .run      (run),
    .out_lvl  (cw.out_lvl),
    .ft_en    (cw.ft_en),
    .ofie     (ofie),
    .osc_fail (osc_fail),
    .ft_o     (ft_o),
    .out_o    (out_o)
  );

  AST_RESET_RELEASED: assert property (@(posedge clk)
    $past(rst) |-> (out_o && ft_o && !sec_tick)); // R12

endmodule

// File: tb/cal_divider_tb_top.sv
`timescale 1ns/1ps
module cal_divider_tb_top;

  localparam int PRE_W   = 10;
  localparam int SPM     = 2;
  localparam int SEC_LEN = 1 << PRE_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_rst = 1'b0;
  logic [7:0] cal_reg = 8'h00;
  logic       stop = 1'b0;
  logic       ofie = 1'b0;
  logic       osc_fail = 1'b0;
  logic       sec_tick, ft_o, out_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = !clk;

  cal_divider #(.PRE_W(PRE_W), .SEC_PER_MIN(SPM)) dut_i (
    .clk(clk), .rst(rst), .div_rst(div_rst), .cal_reg(cal_reg),
    .stop(stop), .ofie(ofie), .osc_fail(osc_fail),
    .sec_tick(sec_tick), .ft_o(ft_o), .out_o(out_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int k, bit sgn, int mag);
    int  m;
    bit  adj;
    m   = (k / SPM) % 64;
    adj = ((k % SPM) == 0) && (mag != 0) && (m < 2 * mag);
    return SEC_LEN + (adj ? (sgn ? -128 : 256) : 0);
  endfunction

  task automatic restart();
    @(negedge clk) div_rst = 1'b1;
    @(negedge clk) div_rst = 1'b0;
  endtask

  // measure n seconds after a restart and compare each length
  task automatic measure(input int n, input bit sgn, input int mag,
                         input string tag_adj, input string tag_nom);
    for (int k = 0; k < n; k++) begin
      int len;
      int exp;
      int m;
      len = 0;
      exp = exp_len(k, sgn, mag);
      m   = (k / SPM) % 64;
      do begin
        @(negedge clk);
        len++;
      end while (!sec_tick);
      if (exp != SEC_LEN)
        check(len == exp, tag_adj, len, exp);
      else
        check(len == exp, (m >= 62) ? "R6" : tag_nom, len, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sec_tick == 1'b0, "R12", sec_tick, 0);
    check(out_o == 1'b1, "R12", out_o, 1);
    check(ft_o == 1'b1, "R12", ft_o, 1);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_nominal();
    cal_reg = 8'h00;                 // sign 0, magnitude 0
    restart();
    measure(4, 1'b0, 0, "R1", "R1");
    cal_reg = 8'h20;                 // sign 1, magnitude 0: no trim (R2)
    restart();
    measure(4, 1'b1, 0, "R2", "R2");
  endtask

  task automatic t_positive();
    cal_reg = 8'h22;                 // speed up, N=2 -> minutes 0..3
    restart();
    measure(10, 1'b1, 2, "R3", "R5");
  endtask

  task automatic t_negative();
    cal_reg = 8'h01;                 // slow down, N=1 -> minutes 0..1
    restart();
    measure(6, 1'b0, 1, "R4", "R5");
  endtask

  task automatic t_full_cycle();
    cal_reg = 8'h3F;                 // speed up, N=31 -> minutes 0..61
    restart();
    measure(64 * SPM + 2, 1'b1, 31, "R5", "R5");
  endtask

  task automatic t_div_reset();
    cal_reg = 8'h21;                 // speed up, N=1
    restart();
    for (int i = 0; i < 2 * SPM; i++) begin
      do @(negedge clk); while (!sec_tick);
    end
    repeat (500) @(negedge clk);     // now in minute 2 (untrimmed)
    restart();
    measure(1, 1'b1, 1, "R8", "R8");
  endtask

  task automatic t_stop();
    int len;
    int ticks;
    cal_reg = 8'h00;
    restart();
    repeat (300) @(negedge clk);
    stop  = 1'b1;
    ticks = 0;
    repeat (200) begin
      @(negedge clk);
      if (sec_tick) ticks++;
    end
    check(ticks == 0, "R7", ticks, 0);
    stop = 1'b0;
    len  = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!sec_tick);
    check(len == SEC_LEN - 300, "R7", len, SEC_LEN - 300);
  endtask

  task automatic t_ft();
    int bad;
    logic prev;
    cal_reg = 8'hE5;                 // out=1, test=1, speed up, N=5
    stop    = 1'b0;
    restart();
    @(negedge clk);
    prev = ft_o;
    bad  = 0;
    for (int i = 0; i < 400; i++) begin  // spans the 128-cycle skip
      @(negedge clk);
      if (ft_o == prev) bad++;
      prev = ft_o;
    end
    check(bad == 0, "R9", bad, 0);
    cal_reg = 8'hA5;                 // test enable off
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (!ft_o) bad++; end
    check(bad == 0, "R9", bad, 0);
    cal_reg = 8'h65;                 // output level 0
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (!ft_o) bad++; end
    check(bad == 0, "R9", bad, 0);
    cal_reg = 8'hE5;
    stop    = 1'b1;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (!ft_o) bad++; end
    check(bad == 0, "R9", bad, 0);
    stop = 1'b0;
  endtask

  task automatic t_out();
    ofie = 1'b0; osc_fail = 1'b1;
    cal_reg = 8'h00;
    @(negedge clk); @(negedge clk);
    check(out_o == 1'b0, "R10", out_o, 0);
    cal_reg = 8'h80;
    @(negedge clk);
    check(out_o == 1'b1, "R10", out_o, 1);
    cal_reg = 8'h80; ofie = 1'b1;    // fail flagged, reporting on
    @(negedge clk);
    check(out_o == 1'b0, "R11", out_o, 0);
    osc_fail = 1'b0;                 // oscillator running again
    @(negedge clk);
    check(out_o == 1'b1, "R11", out_o, 1);
    osc_fail = 1'b1;
    @(negedge clk);
    check(out_o == 1'b0, "R11", out_o, 0);
    ofie = 1'b0;                     // reporting cleared
    @(negedge clk);
    check(out_o == 1'b1, "R11", out_o, 1);
    osc_fail = 1'b0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=195000 expected=<195000 cycles");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_out();
    t_ft();
    t_nominal();
    t_positive();
    t_negative();
    t_stop();
    t_div_reset();
    t_full_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule